// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block receives bytes over a two-wire link made of a clock line and a data line. As clock master it drives the clock line at a rate set by a prescaler. As clock slave it follows a clock driven by the far end. The data line is sampled on every rising clock edge, with the least significant bit first. After the eighth bit the shift register moves its byte into a holding register and raises a ready flag. The host then collects the byte with a read strobe.

In master mode the clock does not pause between bytes, so bytes arrive back to back for as long as the host reads each one in time. A host that falls behind causes an overrun. The block detects it at the falling edge of a byte's eighth clock, raises a sticky flag and keeps the earlier byte. To end a transfer, the host holds the stop request high while it reads. The byte then in progress finishes, the clock stops with the line high, and the block waits until enable is cleared.

The controller has three states:
- `ST_IDLE`: the block is disabled. It leaves for `ST_RECV` when enable is set.
- `ST_RECV`: the block is receiving. It returns to `ST_IDLE` when enable is cleared. It moves to `ST_HALT` when a byte completes while a stop is armed.
- `ST_HALT`: the block is parked. It returns to `ST_IDLE` when enable is cleared.

Top module: `sync_byte_rx`

## Requirements
- R1: After reset `rx_ready` and `overrun` are 0, `scl_oe` is 0 and `scl_out` is 1.
- R2: While `en` is 0, no clock is driven (`scl_oe` = 0, `scl_out` stays 1), and clock pulses on `scl_in` set no ready flag.
- R3: With `en` = 1 and `master` = 1, `scl_oe` is 1 and `scl_out` toggles every H system clocks, where H = 4 << min(`presc_sel`, 5). This gives 4, 8, 16, 32, 64 and 128. Every select value of 5 or more gives 128.
- R4: Data is sampled on each rising clock edge. The first sampled bit becomes bit 0 of `rx_data` and the eighth becomes bit 7. After the eighth rising edge the byte is moved to `rx_data` and `rx_ready` is set.
- R5: In master mode the clock runs without a gap between bytes. When the third byte becomes ready, exactly 24 falling edges have occurred since enable.
- R6: A cycle with `rd_strobe` high clears `rx_ready` at the clock edge that ends that cycle.
- R7: If `rx_ready` is still 1 at the falling edge of a byte's eighth clock, `overrun` is set and that byte is dropped. `rx_data` keeps the earlier byte.
- R8: `overrun` stays 1, even through reads and further bytes, until a cycle with `ovr_clr` high.
- R9: If `stop_req` is 1 during a read strobe, the byte in progress completes. No further falling clock edge follows and `scl_out` stays 1 until `en` is cleared.
- R10: With `master` = 0, the block takes its clock from `scl_in` through a two-flop synchroniser, receives bytes the same way, and leaves `scl_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Reception enable |
| master | input | 1 | 1: drive the clock, 0: follow the line clock |
| stop_req | input | 1 | Stop after the next byte when high during a read |
| presc_sel | input | 4 | Master half-period select |
| rd_strobe | input | 1 | Host read of the holding register |
| ovr_clr | input | 1 | Host write of zero to the overrun flag |
| scl_in | input | 1 | Clock line input (slave mode) |
| sda_in | input | 1 | Data line input |
| scl_out | output | 1 | Clock line drive value |
| scl_oe | output | 1 | Clock line drive enable |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | A received byte is waiting |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench checks bit order with asymmetric byte values. A receiver that shifts the wrong way returns those bytes mirrored. It counts falling clock edges across three consecutive bytes, so a clock that pauses between bytes would show too few edges. In the overrun case the host skips one read. A design that judged overrun late, or wrote the new byte anyway, would show the second byte in `rx_data` or leave `overrun` clear. In the stop case the bench checks that the clock stays high after the last byte. It also measures clock periods at three prescaler settings, so a mistake in the divide ratio shows up as a wrong period.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    localparam int HALF_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_HALT = 2'd2
    } rx_state_t;

    // half-period in system clocks: 4 << min(sel, 5)
    function automatic logic [HALF_W-1:0] half_period(input logic [3:0] sel);
        logic [2:0] e;
        e = (sel > 4'd5) ? 3'd5 : sel[2:0];
        return 8'd4 << e;
    endfunction
endpackage

// File: rtl/sbr_clkgen.sv
module sbr_clkgen
    import sbr_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             scl_q,
    output logic             rise_p,
    output logic             fall_p
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;

    assign half = half_period(sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            scl_q  <= 1'b1;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (!run) begin
                cnt   <= '0;
                scl_q <= 1'b1;
            end else if (cnt >= half - 1'b1) begin
                cnt    <= '0;
                scl_q  <= ~scl_q;
                rise_p <= ~scl_q;
                fall_p <= scl_q;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: the divider count never passes the selected half-period
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sel) |-> cnt < half);
    // R3: an idle generator parks the clock high
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> scl_q);
endmodule

// File: rtl/sbr_sync.sv
module sbr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic rise_p,
    output logic fall_p
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff   <= 2'b11;
            sda_ff   <= 2'b11;
            scl_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[0], scl_in};
            sda_ff   <= {sda_ff[0], sda_in};
            scl_prev <= scl_ff[1];
        end
    end

    assign sda_s  = sda_ff[1];
    assign rise_p = scl_ff[1] & ~scl_prev;
    assign fall_p = ~scl_ff[1] & scl_prev;
endmodule

// File: rtl/sync_byte_rx.sv
module sync_byte_rx
    import sbr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              stop_req,
    input  logic [SEL_W-1:0]  presc_sel,
    input  logic              rd_strobe,
    input  logic              ovr_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              scl_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              overrun
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    rx_state_t         state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              drop_q;
    logic              armed_q;

    logic g_scl, g_rise, g_fall;
    logic s_rise, s_fall, sda_s;
    logic rise, fall, run, byte_done, last_fall;

    assign run = (state == ST_RECV) && master && en;

    sbr_clkgen #(.SEL_W(SEL_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .sel    (presc_sel),
        .scl_q  (g_scl),
        .rise_p (g_rise),
        .fall_p (g_fall)
    );

    sbr_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .sda_s  (sda_s),
        .rise_p (s_rise),
        .fall_p (s_fall)
    );

    assign rise      = master ? g_rise : s_rise;
    assign fall      = master ? g_fall : s_fall;
    assign byte_done = (state == ST_RECV) && rise && (bit_cnt == LAST_BIT);
    assign last_fall = (state == ST_RECV) && fall && (bit_cnt == LAST_BIT);
    assign scl_out   = master ? g_scl : 1'b1;
    assign scl_oe    = master && en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (en) state_nx = ST_RECV;
            ST_RECV: begin
                if (!en)                       state_nx = ST_IDLE;
                else if (byte_done && armed_q) state_nx = ST_HALT;
            end
            ST_HALT: if (!en) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_ready <= 1'b0;
            overrun  <= 1'b0;
            drop_q   <= 1'b0;
            armed_q  <= 1'b0;
        end else begin
            if (state != ST_RECV) begin
                bit_cnt <= '0;
                drop_q  <= 1'b0;
            end else begin
                if (rise) begin
                    shreg   <= {sda_s, shreg[DATA_W-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (last_fall && rx_ready) drop_q <= 1'b1;
                if (byte_done) begin
                    drop_q <= 1'b0;
                    if (!drop_q) rx_data <= {sda_s, shreg[DATA_W-1:1]};
                end
            end

            if (byte_done && !drop_q) rx_ready <= 1'b1;
            else if (rd_strobe)       rx_ready <= 1'b0;

            if (last_fall && rx_ready) overrun <= 1'b1;
            else if (ovr_clr)          overrun <= 1'b0;

            if (state != ST_RECV)            armed_q <= 1'b0;
            else if (stop_req && rd_strobe)  armed_q <= 1'b1;
            else if (byte_done)              armed_q <= 1'b0;
        end
    end

    // R4: the ready flag only rises right after a selected rising edge
    a_r4_ready_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(rise) && $past(state == ST_RECV));
    // R7: overrun only appears while a byte was already waiting
    a_r7_ovr_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_ready));
    // R7: the holding register never changes under an unread byte
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> !$past(rx_ready));
    // R8: overrun is sticky until cleared
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun);
    // R9: a halted receiver keeps the clock line high
    a_r9_halt_high: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALT |-> scl_out);
endmodule

// File: tb/sync_byte_rx_tb.sv
`timescale 1ns/1ps
module sync_byte_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, master = 1'b0, stop_req = 1'b0;
    logic [3:0] presc_sel = 4'd0;
    logic       rd_strobe = 1'b0, ovr_clr = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       scl_out, scl_oe, rx_ready, overrun;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int falls  = 0;

    always #5 clk = ~clk;

    sync_byte_rx u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master), .stop_req(stop_req),
        .presc_sel(presc_sel), .rd_strobe(rd_strobe), .ovr_clr(ovr_clr),
        .scl_in(scl_in), .sda_in(sda_in), .scl_out(scl_out), .scl_oe(scl_oe),
        .rx_data(rx_data), .rx_ready(rx_ready), .overrun(overrun)
    );

    always @(negedge scl_out) falls++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_read(input logic stop);
        @(negedge clk);
        stop_req  = stop;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        stop_req  = 1'b0;
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (!rx_ready && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (!rx_ready) chk({tag, " ready timeout"}, 32'(rx_ready), 32'd1);
    endtask

    // drives one byte onto the data line, following the master clock
    task automatic m_feed(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge scl_out);
            #1 sda_in = b[i];
        end
    endtask

    // drives one byte as the far-end clock master
    task automatic s_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            scl_in = 1'b0;
            sda_in = b[i];
            cycles(6);
            scl_in = 1'b1;
            cycles(6);
        end
    endtask

    task automatic stop_all;
        @(negedge clk);
        en = 1'b0;
        cycles(3);
        if (rx_ready) host_read(1'b0);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rx_ready", 32'(rx_ready), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        chk("R1 scl_oe", 32'(scl_oe), 32'd0);
        chk("R1 scl_out", 32'(scl_out), 32'd1);
    endtask

    task automatic t_master_stream;
        int f0;
        master = 1'b1;
        presc_sel = 4'd0;
        f0 = falls;
        fork
            begin
                m_feed(8'hA5);
                m_feed(8'h3C);
                m_feed(8'hF0);
            end
            begin
                @(negedge clk);
                en = 1'b1;
                cycles(2);
                chk("R3 scl_oe in master", 32'(scl_oe), 32'd1);
                wait_ready("R4");
                chk("R4 first byte", 32'(rx_data), 32'hA5);
                host_read(1'b0);
                chk("R6 ready cleared by read", 32'(rx_ready), 32'd0);
                wait_ready("R5");
                chk("R5 second byte", 32'(rx_data), 32'h3C);
                host_read(1'b0);
                wait_ready("R5");
                chk("R4 third byte lsb first", 32'(rx_data), 32'hF0);
                chk("R5 falls without gap", 32'(falls - f0), 32'd24);
            end
        join
        stop_all();
    endtask

    task automatic t_overrun;
        int n = 0;
        master = 1'b1;
        fork
            begin
                m_feed(8'h12);
                m_feed(8'h34);
                m_feed(8'h9E);
            end
            begin
                @(negedge clk);
                en = 1'b1;
                wait_ready("R7");
                chk("R7 first byte", 32'(rx_data), 32'h12);
                while (!overrun && n < 4000) begin
                    @(negedge clk);
                    n++;
                end
                chk("R7 overrun set", 32'(overrun), 32'd1);
                cycles(10);
                chk("R7 holding kept", 32'(rx_data), 32'h12);
                chk("R7 ready still set", 32'(rx_ready), 32'd1);
                host_read(1'b0);
                wait_ready("R8");
                chk("R8 next byte after overrun", 32'(rx_data), 32'h9E);
                chk("R8 overrun sticky", 32'(overrun), 32'd1);
                host_read(1'b0);
                chk("R8 overrun survives read", 32'(overrun), 32'd1);
                @(negedge clk);
                ovr_clr = 1'b1;
                @(negedge clk);
                ovr_clr = 1'b0;
                chk("R8 overrun cleared", 32'(overrun), 32'd0);
            end
        join
        stop_all();
    endtask

    task automatic t_stop;
        int f0;
        master = 1'b1;
        f0 = falls;
        fork
            begin
                m_feed(8'h6B);
                m_feed(8'hC1);
            end
            begin
                @(negedge clk);
                en = 1'b1;
                wait_ready("R9");
                chk("R9 byte before stop", 32'(rx_data), 32'h6B);
                host_read(1'b1);
                wait_ready("R9");
                chk("R9 last byte", 32'(rx_data), 32'hC1);
            end
        join
        cycles(80);
        chk("R9 no further clock", 32'(falls - f0), 32'd16);
        chk("R9 clock parked high", 32'(scl_out), 32'd1);
        stop_all();
    endtask

    task automatic t_prescale(input logic [3:0] sel, input int half);
        longint t1, t2;
        master = 1'b1;
        presc_sel = sel;
        @(negedge clk);
        en = 1'b1;
        @(negedge scl_out);
        t1 = $time;
        @(negedge scl_out);
        t2 = $time;
        chk("R3 clock period", 32'(int'(t2 - t1)), 32'(half * 20));
        stop_all();
        presc_sel = 4'd0;
    endtask

    task automatic t_slave;
        master = 1'b0;
        @(negedge clk);
        en = 1'b1;
        s_byte(8'h5A);
        chk("R10 slave ready", 32'(rx_ready), 32'd1);
        chk("R10 slave byte", 32'(rx_data), 32'h5A);
        chk("R10 no clock drive", 32'(scl_oe), 32'd0);
        host_read(1'b0);
        s_byte(8'h81);
        chk("R10 second slave byte", 32'(rx_data), 32'h81);
        stop_all();
    endtask

    task automatic t_disabled;
        int f0;
        master = 1'b0;
        en = 1'b0;
        s_byte(8'hFF);
        cycles(4);
        chk("R2 no byte while disabled", 32'(rx_ready), 32'd0);
        master = 1'b1;
        f0 = falls;
        cycles(300);
        chk("R2 no clock while disabled", 32'(falls - f0), 32'd0);
        chk("R2 no drive while disabled", 32'(scl_oe), 32'd0);
        master = 1'b0;
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_master_stream();
        t_overrun();
        t_stop();
        t_prescale(4'd0, 4);
        t_prescale(4'd2, 16);
        t_prescale(4'd15, 128);
        t_slave();
        t_disabled();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        summary();
    end
endmodule